// File: doc/BRIEF.md
# Bit Rate Clock Generator

This block makes the bit-rate enables for a serial controller with several channels. Each channel has a transmit side and a receive side, and each side is set up on its own. One free-running prescaler, shared by every channel, divides the system clock (nominally about 35 MHz) into five tick streams. A source code for each side picks one tick stream, an external clock pin or, on the transmit side only, the receive bit enable of the same channel. A period value from 1 to 255 then divides the chosen source.

Each output is a one-cycle enable pulse in the system clock domain, one per side per channel. A later shift register uses it as its bit strobe. Software configures the block through a single write port. Each write targets one channel and one of four registers.

Top module: `bitclk_gen`

## Requirements
- R1: Source codes 0, 1, 2, 3 and 4 select internal ticks that repeat every 8, 32, 128, 512 and 2048 system cycles. With a period of 1, the output pulses repeat at that spacing.
- R2: Every output enable is high for exactly one cycle at a time.
- R3: With a period P from 1 to 255, consecutive output pulses are P source ticks apart. For example, code 0 with P=255 gives 2040 cycles.
- R4: A period value of 0 behaves exactly like a period of 1.
- R5: Source code 5 takes ticks from the side's own external clock pin, one tick per rising edge after synchronization. A pin of period T cycles with divisor P gives pulses T*P cycles apart.
- R6: Transmit source code 6 counts the receive bit enables of the same channel, so the transmit spacing is the receive spacing times the transmit period.
- R7: Source code 7 on either side, and code 6 on the receive side, produce no output pulses.
- R8: A new period takes effect at the next reload. The interval already in progress finishes with the old length.
- R9: Writing one channel's or one side's registers does not change the pulse spacing of any other channel or side.
- R10: After reset, both outputs are low. Every source register holds code 7 and every period register holds 1, so nothing pulses until software configures it.
- R11: The write port stores wr_data into the register picked by wr_reg for channel wr_chan when wr_en is high at a clock edge. wr_reg values are: 0 = transmit source (wr_data[2:0]), 1 = receive source (wr_data[2:0]), 2 = transmit period (wr_data[7:0]), 3 = receive period (wr_data[7:0]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_chan | input | CW | Channel addressed by the write |
| wr_reg | input | 2 | Register select (see R11) |
| wr_data | input | 8 | Write data |
| tx_clk_pin | input | NCH | External transmit clock pins, one per channel |
| rx_clk_pin | input | NCH | External receive clock pins, one per channel |
| tx_bit_en | output | NCH | Transmit bit enable pulses |
| rx_bit_en | output | NCH | Receive bit enable pulses |

## Verification
A wrong prescaler tap or source mux shows at the ports as a pulse spacing off by a factor of four or more. It appears in the first full interval after configuration, within at most a few thousand cycles. A wrong divider count or reload shows as a wrong interval length after one or two pulses. A period captured too early shows as a shortened interval across the write. A leaking off code shows as any pulse in a window that should be silent. Every one of these faults is visible within one or two intervals of the configured rate.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int NTAP = 5;
  localparam int PW   = 8;

  typedef enum logic [2:0] {
    SRC_T0    = 3'd0,
    SRC_T1    = 3'd1,
    SRC_T2    = 3'd2,
    SRC_T3    = 3'd3,
    SRC_T4    = 3'd4,
    SRC_PIN   = 3'd5,
    SRC_CHAIN = 3'd6,
    SRC_OFF   = 3'd7
  } src_e;

  typedef enum logic [1:0] {
    REG_TX_SRC = 2'd0,
    REG_RX_SRC = 2'd1,
    REG_TX_DIV = 2'd2,
    REG_RX_DIV = 2'd3
  } reg_e;

  // spacing in system cycles of prescaler tap k
  function automatic int tap_span(input int k);
    return 8 << (2 * k);
  endfunction

  // value loaded into a divider at reload; zero is promoted to one
  function automatic logic [PW-1:0] load_val(input logic [PW-1:0] p);
    return (p == '0) ? PW'(1) : p;
  endfunction
endpackage

// File: rtl/brg_prescale.sv
module brg_prescale
  import brg_pkg::*;
#(
  parameter int TAPS = NTAP
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TAPS-1:0] tap
);
  localparam int CW = 2 * TAPS + 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    localparam logic [CW-1:0] MASK = CW'(tap_span(k) - 1);
    assign tap[k] = (cnt & MASK) == '0;

    if (k > 0) begin : g_nest
      // R1
      taps_nested_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tap[k] |-> tap[k-1]);
    end
  end

  // R1
  tap0_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tap[0] |=> !tap[0]);
endmodule

// File: rtl/brg_edge.sv
module brg_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic tick
);
  logic [2:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], pin};
  end

  assign tick = sh[1] & ~sh[2];

  // R5
  edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/brg_div.sv
module brg_div
  import brg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [PW-1:0] period,
  output logic          en
);
  logic [PW-1:0] left;
  logic          expire;

  assign expire = tick && (left <= PW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left <= PW'(1);
      en   <= 1'b0;
    end else begin
      en <= expire;
      if (expire)    left <= load_val(period);
      else if (tick) left <= left - 1'b1;
    end
  end

  // R3
  pulse_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> $past(tick));

  // R2
  no_double_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> !en);
endmodule

// File: rtl/bitclk_gen.sv
module bitclk_gen
  import brg_pkg::*;
#(
  parameter  int NCH = 4,
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [CW-1:0]  wr_chan,
  input  logic [1:0]     wr_reg,
  input  logic [7:0]     wr_data,
  input  logic [NCH-1:0] tx_clk_pin,
  input  logic [NCH-1:0] rx_clk_pin,
  output logic [NCH-1:0] tx_bit_en,
  output logic [NCH-1:0] rx_bit_en
);
  logic [NTAP-1:0] tap;
  src_e            tx_src [NCH];
  src_e            rx_src [NCH];
  logic [PW-1:0]   tx_div [NCH];
  logic [PW-1:0]   rx_div [NCH];

  brg_prescale #(.TAPS(NTAP)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .tap  (tap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        tx_src[i] <= SRC_OFF;
        rx_src[i] <= SRC_OFF;
        tx_div[i] <= PW'(1);
        rx_div[i] <= PW'(1);
      end
    end else if (wr_en) begin
      case (reg_e'(wr_reg))
        REG_TX_SRC: tx_src[wr_chan] <= src_e'(wr_data[2:0]);
        REG_RX_SRC: rx_src[wr_chan] <= src_e'(wr_data[2:0]);
        REG_TX_DIV: tx_div[wr_chan] <= wr_data[PW-1:0];
        default:    rx_div[wr_chan] <= wr_data[PW-1:0];
      endcase
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic tx_pin_tick, rx_pin_tick;
    logic tx_t, rx_t;

    brg_edge u_txe (.clk(clk), .rst_n(rst_n), .pin(tx_clk_pin[c]), .tick(tx_pin_tick));
    brg_edge u_rxe (.clk(clk), .rst_n(rst_n), .pin(rx_clk_pin[c]), .tick(rx_pin_tick));

    always_comb begin
      case (tx_src[c])
        SRC_T0:    tx_t = tap[0];
        SRC_T1:    tx_t = tap[1];
        SRC_T2:    tx_t = tap[2];
        SRC_T3:    tx_t = tap[3];
        SRC_T4:    tx_t = tap[4];
        SRC_PIN:   tx_t = tx_pin_tick;
        SRC_CHAIN: tx_t = rx_bit_en[c];
        default:   tx_t = 1'b0;
      endcase
    end

    always_comb begin
      case (rx_src[c])
        SRC_T0:  rx_t = tap[0];
        SRC_T1:  rx_t = tap[1];
        SRC_T2:  rx_t = tap[2];
        SRC_T3:  rx_t = tap[3];
        SRC_T4:  rx_t = tap[4];
        SRC_PIN: rx_t = rx_pin_tick;
        default: rx_t = 1'b0;
      endcase
    end

    brg_div u_txd (.clk(clk), .rst_n(rst_n), .tick(tx_t), .period(tx_div[c]), .en(tx_bit_en[c]));
    brg_div u_rxd (.clk(clk), .rst_n(rst_n), .tick(rx_t), .period(rx_div[c]), .en(rx_bit_en[c]));

    // R7
    rx_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rx_src[c]) inside {SRC_CHAIN, SRC_OFF}) |-> !rx_bit_en[c]);

    // R7
    tx_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(tx_src[c]) == SRC_OFF) |-> !tx_bit_en[c]);
  end
endmodule

// File: tb/bitclk_gen_bench.sv
module bitclk_gen_bench;
  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [1:0]     wr_chan = '0;
  logic [1:0]     wr_reg = '0;
  logic [7:0]     wr_data = '0;
  logic [NCH-1:0] tx_clk_pin = '0;
  logic [NCH-1:0] rx_clk_pin = '0;
  logic [NCH-1:0] tx_bit_en, rx_bit_en;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  int tx_half [NCH];
  int rx_half [NCH];
  int tx_pc [NCH];
  int rx_pc [NCH];

  bitclk_gen #(.NCH(NCH)) u_bitclk_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan), .wr_reg(wr_reg),
    .wr_data(wr_data), .tx_clk_pin(tx_clk_pin), .rx_clk_pin(rx_clk_pin),
    .tx_bit_en(tx_bit_en), .rx_bit_en(rx_bit_en)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // external pin drivers: toggle every half cycles when half > 0
  initial begin
    for (int i = 0; i < NCH; i++) begin
      tx_half[i] = 0; rx_half[i] = 0; tx_pc[i] = 0; rx_pc[i] = 0;
    end
    forever begin
      @(negedge clk);
      for (int i = 0; i < NCH; i++) begin
        if (tx_half[i] > 0) begin
          tx_pc[i]++;
          if (tx_pc[i] >= tx_half[i]) begin tx_pc[i] = 0; tx_clk_pin[i] = ~tx_clk_pin[i]; end
        end
        if (rx_half[i] > 0) begin
          rx_pc[i]++;
          if (rx_pc[i] >= rx_half[i]) begin rx_pc[i] = 0; rx_clk_pin[i] = ~rx_clk_pin[i]; end
        end
      end
    end
  end

  function automatic int src_cycles(input int code);
    int s = 8;
    for (int i = 0; i < code; i++) s = s * 4;
    return s;
  endfunction

  function automatic int eff_p(input int p);
    return (p == 0) ? 1 : p;
  endfunction

  function automatic logic out_bit(input bit tx, input int ch);
    return tx ? tx_bit_en[ch] : rx_bit_en[ch];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int rg, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_chan = 2'(ch); wr_reg = 2'(rg); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_pulse(input bit tx, input int ch, output int stamp);
    stamp = -1;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (out_bit(tx, ch)) begin stamp = cyc; break; end
    end
  endtask

  // skips the first pulse, checks width of the next, returns the following gap
  task automatic measure(input bit tx, input int ch, input string req, output int gap);
    int a, b, d;
    wait_pulse(tx, ch, d);
    wait_pulse(tx, ch, a);
    @(negedge clk);
    chk("R2 width", int'(out_bit(tx, ch)), 0);
    wait_pulse(tx, ch, b);
    gap = (a < 0 || b < 0) ? -1 : b - a;
  endtask

  task automatic count_pulses(input bit tx, input int ch, input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (out_bit(tx, ch)) cnt++;
    end
  endtask

  // bring a side back to code 0 / period 1 so its count is short
  task automatic drain(input bit tx, input int ch);
    int d;
    wr(ch, tx ? 2 : 3, 1);
    wr(ch, tx ? 0 : 1, 0);
    wait_pulse(tx, ch, d);
    wait_pulse(tx, ch, d);
  endtask

  initial begin
    int g, n, a, b, c;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    chk("R10 tx reset", int'(tx_bit_en), 0);
    chk("R10 rx reset", int'(rx_bit_en), 0);
    rst_n = 1'b1;

    // R10: unconfigured block stays silent
    n = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (tx_bit_en != 0 || rx_bit_en != 0) n++;
    end
    chk("R10 silent", n, 0);

    // R1 / R11: tap0, period 1, ch0 tx
    wr(0, 0, 0);
    measure(1, 0, "R1", g);
    chk("R1 tap0", g, src_cycles(0) * 1);

    // R3: tap0, period 255, ch1 rx
    wr(1, 3, 255); wr(1, 1, 0);
    measure(0, 1, "R3", g);
    chk("R3 div255", g, src_cycles(0) * 255);

    // R1: tap4, period 1, ch2 rx
    wr(2, 1, 4);
    measure(0, 2, "R1", g);
    chk("R1 tap4", g, src_cycles(4));

    // R4: period 0 acts as 1, tap1 ch3 tx
    wr(3, 2, 0); wr(3, 0, 1);
    measure(1, 3, "R4", g);
    chk("R4 zero period", g, src_cycles(1) * eff_p(0));

    // R5: external receive pin on ch0, period 6 cycles, divisor 4
    rx_half[0] = 3;
    wr(0, 3, 4); wr(0, 1, 5);
    measure(0, 0, "R5", g);
    chk("R5 pin", g, 6 * 4);

    // R6: ch0 tx chained on ch0 rx, divisor 3
    wr(0, 2, 3); wr(0, 0, 6);
    measure(1, 0, "R6", g);
    chk("R6 chain", g, 6 * 4 * 3);

    // R7: rx code 6 and tx code 7 stay silent
    wr(1, 1, 6);
    repeat (3) @(negedge clk);
    count_pulses(0, 1, 600, n);
    chk("R7 rx code6", n, 0);
    wr(2, 0, 7);
    count_pulses(1, 2, 600, n);
    chk("R7 tx code7", n, 0);

    // R8: period change lands at next reload (ch1 tx, tap0)
    wr(1, 2, 10); wr(1, 0, 0);
    wait_pulse(1, 1, a);
    wait_pulse(1, 1, a);
    wr(1, 2, 3);
    wait_pulse(1, 1, b);
    wait_pulse(1, 1, c);
    chk("R8 old interval", b - a, 80);
    chk("R8 new interval", c - b, 24);

    // R9: writes to other channel/side leave ch1 tx untouched
    wr(2, 2, 200); wr(1, 1, 3); wr(3, 3, 9);
    measure(1, 1, "R9", g);
    chk("R9 isolation", g, 24);

    // R1 / R3: random taps and periods
    for (int t = 0; t < 6; t++) begin
      int ch, k, p, mx;
      bit tx;
      ch = int'($urandom_range(0, NCH - 1));
      tx = 1'($urandom_range(0, 1));
      k  = int'($urandom_range(0, 4));
      p  = int'($urandom_range(1, 255));
      mx = 2048 / src_cycles(k);
      if (p > mx) p = 1 + (p % mx);
      drain(tx, ch);
      wr(ch, tx ? 0 : 1, k);
      wr(ch, tx ? 2 : 3, p);
      measure(tx, ch, "R3", g);
      chk("R1/R3 random", g, src_cycles(k) * p);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    total++;
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", cyc, 190000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule